// File: doc/BRIEF.md
# Bit-Serial Non-Restoring Division Step Engine

This block carries out non-restoring binary division one bit at a time. It keeps a 32-bit partial remainder register and three flags: Q holds the partial remainder's sign state, M the divisor sign and T the latest quotient bit. Each step shifts the remainder register left, shifts T in at the bottom, and then either adds or subtracts the divisor. The choice depends on whether the previous Q matches M. The step then rebuilds Q from the bit shifted out, the carry or borrow, and M.

A small sequencer runs a chosen number of steps (1 to 32) after a start pulse and flags completion with a one-cycle done pulse. While idle, the host can load the remainder register directly and issue either a signed or an unsigned preparation command to seed the flags before a run. The bits of each step's T shift into the low end of the register, so a 16-bit unsigned divide finishes in 16 steps: put the divisor in the upper half-word and the dividend in the low half-word.

Top module: `divstep_engine`

## Requirements
- R1: A synchronous active-low reset clears the remainder register, Q, M, T, busy and done.
- R2: While idle, `load_en` high writes `load_value` into the remainder register at the next clock edge.
- R3: While idle, `prep_unsigned` high (with `prep_signed` low) clears Q, M and T at the next clock edge.
- R4: While idle, `prep_signed` high sets Q to bit 31 of the remainder register as it stood before that edge, M to bit 31 of `divisor`, and T to Q XOR M. It takes priority over `prep_unsigned`.
- R5: Each step sets the register to ({reg[30:0], T} minus divisor) when the old Q equals M, or to ({reg[30:0], T} plus divisor) when they differ, in 32-bit modular arithmetic.
- R6: Each step sets Q to old reg[31] XOR M XOR F. F is the borrow of the subtraction (the shifted value is below the divisor as unsigned numbers) or the carry out of bit 31 of the addition.
- R7: After each step, T is 1 exactly when the new Q equals M, and M is left unchanged.
- R8: A start pulse taken while idle with `step_count` from 1 to 32 raises busy at the next edge, and exactly `step_count` steps follow on the next `step_count` edges.
- R9: done is high for exactly the one cycle that follows the last step's edge; busy falls at that same edge.
- R10: While busy, start, `load_en` and both preparation commands have no effect. A start with `step_count` of 0 or above 32 is ignored.
- R11: Load the dividend d (below 65536) into the register, drive `divisor` with v<<16 (v nonzero, d < v<<16), issue an unsigned preparation and run 16 steps. The quotient d/v is then {reg[14:0], T}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write `load_value` into the remainder register (idle only) |
| load_value | input | 32 | Value for the remainder register |
| prep_signed | input | 1 | Seed the flags for signed division (idle only) |
| prep_unsigned | input | 1 | Clear the flags for unsigned division (idle only) |
| divisor | input | 32 | Divisor, held steady for the whole run |
| start | input | 1 | Begin a run of `step_count` steps (idle only) |
| step_count | input | 6 | Number of steps, 1 to 32 |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse after the last step |
| rem_out | output | 32 | Remainder register |
| q_flag | output | 1 | Q flag |
| m_flag | output | 1 | M flag |
| t_flag | output | 1 | T flag |

## Verification
The bench targets these corner cases:
- **Carry and borrow cases.** Steps where the shifted value is just below or above the divisor, and additions that wrap past 2^32. A design that compared the wrong way round, or used a signed compare, would flip Q and push every later quotient bit off course.
- **Both preparation modes with negative operands.** A mix-up of XOR and XNOR in the seeding of T shows up here at once.
- **Run lengths at the limits.** Runs of 1 and 32 steps test the counter boundaries. Counts of 0 and 33 must be ignored, and a counter that mishandled them would spin or run too short.
- **Commands during a run.** Loads, preparations and starts driven while busy must change nothing. Any leak would corrupt the remainder.

Complete 16-bit divisions compared with a software quotient close the loop.

// File: rtl/divstep_pkg.sv
// Package: shared types for the division step engine.
// Assumes: flag ordering below is used consistently by all submodules.
package divstep_pkg;

    // Flag triple carried between the register stage and the step logic.
    typedef struct packed {
        logic q;   // remainder sign state
        logic m;   // divisor sign
        logic t;   // latest quotient bit / carry-in for the next shift
    } divflags_t;

endpackage

// File: rtl/divstep_alu.sv
// Module: divstep_alu
// Computes one non-restoring division step combinationally: shift left with
// T entering bit 0, add or subtract the divisor depending on Q versus M, and
// rebuild Q and T from the shifted-out bit, the carry/borrow and M.
// Assumes: caller registers the outputs only when a step is due.
module divstep_alu
    import divstep_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rem_in,
    input  logic [DATA_W-1:0] dvsr,
    input  divflags_t         flags_in,
    output logic [DATA_W-1:0] rem_nx,
    output divflags_t         flags_nx
);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] result;
    logic              out_bit;
    logic              do_sub;
    logic              cb_flag;
    logic              new_q;

    // Shift stage and operation selection.
    always_comb begin
        shifted = {rem_in[DATA_W-2:0], flags_in.t};
        out_bit = rem_in[DATA_W-1];
        do_sub  = (flags_in.q == flags_in.m);
    end

    // Add or subtract and detect carry/borrow by unsigned comparison.
    always_comb begin
        if (do_sub) begin
            result  = shifted - dvsr;
            cb_flag = (result > shifted);
        end else begin
            result  = shifted + dvsr;
            cb_flag = (result < shifted);
        end
    end

    // Rebuild the flags for the next step.
    always_comb begin
        new_q      = out_bit ^ cb_flag ^ flags_in.m;
        rem_nx     = result;
        flags_nx.q = new_q;
        flags_nx.m = flags_in.m;
        flags_nx.t = (new_q == flags_in.m);
    end

endmodule

// File: rtl/divstep_seq.sv
// Module: divstep_seq
// Step sequencer: accepts a start with a count in 1..MAX_STEPS while idle,
// asserts busy for exactly that many cycles (one step each), then pulses done.
// Assumes: synchronous active-low reset; out-of-range counts are dropped.
module divstep_seq #(
    parameter int MAX_STEPS = 32,
    localparam int CNT_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] step_count,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] remaining;
    logic             count_ok;

    // Validity of the requested step count.
    always_comb begin
        count_ok = (step_count != '0) && (step_count <= CNT_W'(MAX_STEPS));
    end

    // Counter, busy and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                remaining <= remaining - 1'b1;
                if (remaining == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start && count_ok) begin
                remaining <= step_count;
                busy      <= 1'b1;
            end
        end
    end

    // R8: while busy the remaining count stays within the legal range.
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remaining != '0) && (remaining <= CNT_W'(MAX_STEPS)));

    // R9: done never lasts more than one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done only follows a cycle in which a step was running.
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

endmodule

// File: rtl/divstep_engine.sv
// Module: divstep_engine (top)
// Holds the remainder register and Q/M/T flags, applies load and preparation
// commands while idle, and applies one division step per cycle while the
// sequencer reports busy.
// Assumes: divisor is held steady for the duration of a run.
module divstep_engine
    import divstep_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MAX_STEPS = 32,
    localparam int CNT_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_value,
    input  logic              prep_signed,
    input  logic              prep_unsigned,
    input  logic [DATA_W-1:0] divisor,
    input  logic              start,
    input  logic [CNT_W-1:0]  step_count,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rem_out,
    output logic              q_flag,
    output logic              m_flag,
    output logic              t_flag
);

    logic [DATA_W-1:0] rem_r;
    logic [DATA_W-1:0] rem_nx;
    divflags_t         flags_r;
    divflags_t         flags_nx;
    divflags_t         signed_seed;

    divstep_seq #(.MAX_STEPS(MAX_STEPS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step_count (step_count),
        .busy       (busy),
        .done       (done)
    );

    divstep_alu #(.DATA_W(DATA_W)) u_alu (
        .rem_in   (rem_r),
        .dvsr     (divisor),
        .flags_in (flags_r),
        .rem_nx   (rem_nx),
        .flags_nx (flags_nx)
    );

    // Flag seed for the signed preparation command.
    always_comb begin
        signed_seed.q = rem_r[DATA_W-1];
        signed_seed.m = divisor[DATA_W-1];
        signed_seed.t = rem_r[DATA_W-1] ^ divisor[DATA_W-1];
    end

    // Remainder register: step result while busy, host load while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
        end else if (busy) begin
            rem_r <= rem_nx;
        end else if (load_en) begin
            rem_r <= load_value;
        end
    end

    // Flag register: step result while busy, preparation commands while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_r <= '0;
        end else if (busy) begin
            flags_r <= flags_nx;
        end else if (prep_signed) begin
            flags_r <= signed_seed;
        end else if (prep_unsigned) begin
            flags_r <= '0;
        end
    end

    // Output mapping.
    always_comb begin
        rem_out = rem_r;
        q_flag  = flags_r.q;
        m_flag  = flags_r.m;
        t_flag  = flags_r.t;
    end

    // R3: unsigned preparation while idle leaves all flags clear.
    assert_unsigned_prep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prep_unsigned && !prep_signed) |=> (!q_flag && !m_flag && !t_flag));

    // R7: after a step, T reports whether Q matches M.
    assert_t_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (t_flag == (q_flag == m_flag)));

    // R7/R10: M is never altered by a step, even with commands pending.
    assert_m_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(m_flag));

    // R10: a load request while busy does not replace the register with load_value
    // unless the step result happens to equal it.
    assert_step_not_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_en) |=> (rem_out == $past(rem_nx)));

endmodule

// File: tb/tb_divstep_engine.sv
// Bench for divstep_engine: a behavioural reference model stepped on every
// clock and compared on every falling edge, plus directed checks.
module tb_divstep_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic [31:0] load_value;
    logic        prep_signed;
    logic        prep_unsigned;
    logic [31:0] divisor;
    logic        start;
    logic [5:0]  step_count;
    logic        busy, done, q_flag, m_flag, t_flag;
    logic [31:0] rem_out;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit cmp_en   = 1'b0;

    // Reference model state.
    logic [31:0] r_rem = '0;
    logic        r_q = 0, r_m = 0, r_t = 0, r_busy = 0, r_done = 0;
    int          r_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    divstep_engine dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_value(load_value),
        .prep_signed(prep_signed), .prep_unsigned(prep_unsigned),
        .divisor(divisor), .start(start), .step_count(step_count),
        .busy(busy), .done(done), .rem_out(rem_out),
        .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model: one update per rising edge from the sampled inputs.
    always @(posedge clk) begin
        logic [32:0] wide;
        logic [31:0] sh;
        logic        cb, nq, ob;
        if (!rst_n) begin
            r_rem = '0; r_q = 0; r_m = 0; r_t = 0;
            r_busy = 0; r_done = 0; r_left = 0;
        end else if (r_busy) begin
            sh = {r_rem[30:0], r_t};
            ob = r_rem[31];
            if (r_q == r_m) wide = {1'b0, sh} - {1'b0, divisor};
            else            wide = {1'b0, sh} + {1'b0, divisor};
            cb    = wide[32];
            r_rem = wide[31:0];
            nq    = ob ^ cb ^ r_m;
            r_q   = nq;
            r_t   = (nq == r_m);
            r_left--;
            r_done = (r_left == 0);
            r_busy = (r_left != 0);
        end else begin
            r_done = 0;
            if (prep_signed) begin
                r_q = r_rem[31]; r_m = divisor[31]; r_t = r_rem[31] ^ divisor[31];
            end else if (prep_unsigned) begin
                r_q = 0; r_m = 0; r_t = 0;
            end
            if (load_en) r_rem = load_value;
            if (start && step_count >= 1 && step_count <= 32) begin
                r_busy = 1; r_left = int'(step_count);
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(rem_out == r_rem, "R5 remainder", rem_out, r_rem);
            chk(q_flag == r_q, "R6 q_flag", 32'(q_flag), 32'(r_q));
            chk(t_flag == r_t, "R7 t_flag", 32'(t_flag), 32'(r_t));
            chk(m_flag == r_m, "R4 m_flag", 32'(m_flag), 32'(r_m));
            chk(busy == r_busy, "R8 busy", 32'(busy), 32'(r_busy));
            chk(done == r_done, "R9 done", 32'(done), 32'(r_done));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic quiet();
        load_en = 0; load_value = '0; prep_signed = 0; prep_unsigned = 0;
        start = 0; step_count = '0;
    endtask

    task automatic do_load(input logic [31:0] v);
        load_en = 1; load_value = v;
        @(negedge clk); load_en = 0;
    endtask

    task automatic run_steps(input int n);
        start = 1; step_count = 6'(n);
        @(negedge clk); start = 0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        logic [31:0] seed;
        int          dd, vv, qexp, qgot;
        quiet();
        divisor = '0;
        rst_n   = 0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(rem_out == 0 && !q_flag && !m_flag && !t_flag && !busy && !done,
            "R1 reset", {rem_out[27:0], q_flag, m_flag, t_flag, busy}, 32'h0);
        cmp_en = 1;
        rst_n  = 1;

        // R2: load while idle.
        do_load(32'h9000_0001);
        chk(rem_out == 32'h9000_0001, "R2 load", rem_out, 32'h9000_0001);

        // R4: signed preparation with negative remainder, positive divisor.
        divisor = 32'h0000_0003; prep_signed = 1;
        @(negedge clk); prep_signed = 0;
        chk({q_flag, m_flag, t_flag} == 3'b101, "R4 signed prep", 32'({q_flag, m_flag, t_flag}), 32'b101);
        // R4: both negative; signed wins over unsigned.
        divisor = 32'h8000_0007; prep_signed = 1; prep_unsigned = 1;
        @(negedge clk); prep_signed = 0; prep_unsigned = 0;
        chk({q_flag, m_flag, t_flag} == 3'b110, "R4 signed both neg", 32'({q_flag, m_flag, t_flag}), 32'b110);

        // R3: unsigned preparation.
        prep_unsigned = 1;
        @(negedge clk); prep_unsigned = 0;
        chk({q_flag, m_flag, t_flag} == 3'b000, "R3 unsigned prep", 32'({q_flag, m_flag, t_flag}), 32'b0);

        // R8/R9: five-step run timing.
        divisor = 32'h1234_5678;
        start = 1; step_count = 6'd5;
        @(negedge clk); start = 0;
        chk(busy == 1, "R8 busy after start", 32'(busy), 32'd1);
        repeat (4) @(negedge clk);
        chk(busy == 1 && !done, "R8 still busy before last step", 32'({busy, done}), 32'b10);
        @(negedge clk);
        chk(done == 1 && busy == 0, "R9 done after fifth step", 32'({busy, done}), 32'b01);
        @(negedge clk);
        chk(done == 0, "R9 done one cycle", 32'(done), 32'd0);

        // R10: illegal counts ignored.
        start = 1; step_count = 6'd0;
        @(negedge clk);
        chk(busy == 0, "R10 count zero ignored", 32'(busy), 32'd0);
        step_count = 6'd33;
        @(negedge clk); start = 0;
        chk(busy == 0, "R10 count 33 ignored", 32'(busy), 32'd0);

        // R10: commands during a run have no effect (model tracks the rest).
        do_load(32'h7fff_fff0);
        prep_signed = 1;
        @(negedge clk); prep_signed = 0;
        start = 1; step_count = 6'd3;
        @(negedge clk);
        load_en = 1; load_value = 32'hdead_beef; prep_unsigned = 1; step_count = 6'd20;
        @(negedge clk);
        quiet();
        while (!done) @(negedge clk);
        chk(rem_out == r_rem && m_flag == r_m, "R10 ignored while busy", rem_out, r_rem);
        @(negedge clk);
        chk(busy == 0, "R10 no restart from busy start", 32'(busy), 32'd0);

        // Mixed patterns: both modes, boundary run lengths 1 and 32.
        seed = 32'h1357_9bdf;
        for (int i = 0; i < 12; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            do_load(seed);
            seed = seed * 32'd1664525 + 32'd1013904223;
            divisor = seed;
            if (i % 2 == 0) prep_signed = 1; else prep_unsigned = 1;
            @(negedge clk); prep_signed = 0; prep_unsigned = 0;
            run_steps((i % 3 == 0) ? 32 : ((i % 3 == 1) ? 1 : 7));
            @(negedge clk);
        end

        // R11: 16-bit unsigned divisions against a software quotient.
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin dd = 1000;  vv = 7;   end
                1: begin dd = 65535; vv = 1;   end
                2: begin dd = 12345; vv = 345; end
                3: begin dd = 5;     vv = 9;   end
                4: begin dd = 40000; vv = 200; end
                default: begin dd = 65535; vv = 65535; end
            endcase
            do_load(32'(dd));
            divisor = 32'(vv) << 16;
            prep_unsigned = 1;
            @(negedge clk); prep_unsigned = 0;
            run_steps(16);
            qgot = int'({rem_out[14:0], t_flag});
            qexp = dd / vv;
            chk(qgot == qexp, "R11 quotient", 32'(qgot), 32'(qexp));
            @(negedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule